// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard Controller

This block sequences an in-order instruction pipeline with six equal stages: fetch, decode, address calculation, operand fetch, execute and write. Each stage keeps a valid bit and the full descriptor of the instruction it holds. The controller decides each cycle whether every stage advances, holds or receives a bubble. It draws those decisions from three sources. The first is a single memory port shared between instruction fetch and operand access. The second is a read-after-write dependency between the instruction calculating its operand addresses and older instructions that will write a register. The third is a conditional branch whose outcome becomes known only in the execute stage.

The fetch side presents one instruction descriptor per cycle: a tag, two source register indices, a destination index, a register-write flag, a memory-operand flag, a branch flag and the branch outcome. The instruction is taken on a clock edge when `in_valid` and `fetch_ready` are both high. When `flush` is high, the fetch source must present the branch target in that same cycle. The tag of every instruction that reaches the write stage appears on the retire outputs, and a running count of retired instructions is kept.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: An instruction taken on clock edge E with no hazard in its path is in the write stage (`retire_valid` high, `retire_tag` equal to its tag) after edge E+5. It moves one stage per edge, with its tag unchanged.
- R2: Nine independent instructions offered back to back retire on nine consecutive cycles. The first is taken on edge 1 and the last is in the write stage after edge 14, so the run spans 14 cycles.
- R3: A valid instruction in the execute stage with branch flag 1 and outcome 1 raises `flush` for that one cycle. The decode, address, operand and execute stages are empty after the next edge, and none of the discarded instructions ever retires.
- R4: `fetch_ready` is high during a flush cycle, so the target is taken on the edge that ends it. After the branch retires, no instruction retires for four cycles.
- R5: A branch whose outcome is 0 causes no flush and no lost cycle.
- R6: While the operand stage holds a valid instruction with the memory flag set, and no flush occurs, `port_busy` is high and `fetch_ready` is low. The fetch stage takes a bubble and the later stages advance.
- R7: When the instruction in the address stage has `src_a` or `src_b` equal to the `dst` of a valid instruction with write flag 1 in the operand, execute or write stage, `raw_stall` is high. The fetch, decode and address stages hold, and the operand stage takes a bubble. A dependency on the instruction just ahead costs 3 cycles, and one on the instruction two ahead costs 2.
- R8: A producer whose write flag is 0 never causes a stall, even if its `dst` matches a source.
- R9: A flush takes priority over a stall. In a flush cycle `raw_stall` is low and `fetch_ready` is high, even when a dependency is detected or the port is busy.
- R10: `done_count` increases by one on every edge that follows a cycle in which `retire_valid` is high, and it is unchanged otherwise.
- R11: While `rst_n` is low, all stages are empty, `done_count` is 0, `flush` and `raw_stall` are low, and `fetch_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A descriptor is offered to fetch |
| in_tag | input | 8 | Instruction tag |
| in_src_a | input | 4 | First source register |
| in_src_b | input | 4 | Second source register |
| in_dst | input | 4 | Destination register |
| in_wr_reg | input | 1 | Instruction writes `in_dst` |
| in_mem | input | 1 | Instruction uses the memory port in the operand stage |
| in_branch | input | 1 | Instruction is a conditional branch |
| in_taken | input | 1 | Branch outcome, 1 = taken |
| fetch_ready | output | 1 | Fetch takes the offered descriptor at the next edge |
| flush | output | 1 | Taken branch in execute; present the target now |
| raw_stall | output | 1 | Register dependency stall this cycle |
| port_busy | output | 1 | Operand stage is using the memory port |
| stage_valid | output | 6 | Valid bit per stage, bit 0 = fetch, bit 5 = write |
| stage_tags | output | 48 | Tag per stage, stage s in bits [8s+7:8s] |
| retire_valid | output | 1 | Write stage holds a valid instruction |
| retire_tag | output | 8 | Tag of the instruction in the write stage |
| done_count | output | 16 | Number of retired instructions |

## Verification
The bench targets the places where stage timing is easy to get off by one. A taken branch must discard exactly the four wrong-path instructions and fetch its target in the flush cycle. A design that let one wrong-path instruction through would retire a stray tag, and one that fetched the target a cycle late would shift every later retire time. The bench measures the dependency window at distances one and two. A window that was one stage short or long would change the 3- and 2-cycle penalties, and a design that ignored the write flag would stall where it must not. The bench also combines a flush with both a dependency and a busy port in one cycle, so any design that lets a stall win over the flush retires the target at the wrong time.

// File: rtl/phc_pkg.sv
package phc_pkg;

  localparam int TAG_W = 8;
  localparam int REG_W = 4;
  localparam int N_ST  = 6;

  // stage order is behaviour: index grows with instruction age
  localparam int ST_FETCH = 0;
  localparam int ST_DEC   = 1;
  localparam int ST_ADDR  = 2;
  localparam int ST_OPND  = 3;
  localparam int ST_EXEC  = 4;
  localparam int ST_WRITE = 5;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] dst;
    logic             wr_reg;
    logic             mem;
    logic             branch;
    logic             taken;
  } slot_t;

  // consumer c needs a register that older producer p has yet to write
  function automatic logic reads_from(slot_t c, slot_t p);
    return c.valid && p.valid && p.wr_reg &&
           ((c.src_a == p.dst) || (c.src_b == p.dst));
  endfunction

  function automatic logic redirects(slot_t s);
    return s.valid && s.branch && s.taken;
  endfunction

  function automatic logic uses_port(slot_t s);
    return s.valid && s.mem;
  endfunction

endpackage

// File: rtl/phc_hazard.sv
module phc_hazard
  import phc_pkg::*;
(
  input  slot_t [N_ST-1:0] stg,
  output logic             flush,
  output logic             port_busy,
  output logic             raw_hit,
  output logic             raw_stall,
  output logic             fetch_ready
);

  logic [ST_WRITE:ST_OPND] hit_vec;
  logic                    unused_fields;

  // compare the address-stage sources against every older writer still in flight
  for (genvar k = ST_OPND; k <= ST_WRITE; k++) begin : g_win
    assign hit_vec[k] = reads_from(stg[ST_ADDR], stg[k]);
  end

  assign raw_hit   = |hit_vec;
  assign flush     = redirects(stg[ST_EXEC]);
  assign port_busy = uses_port(stg[ST_OPND]);

  // a flush outranks both stall sources: the stalled work is being discarded
  assign raw_stall   = raw_hit & ~flush;
  assign fetch_ready = flush | (~raw_stall & ~port_busy);

  assign unused_fields = ^stg;

endmodule

// File: rtl/phc_pipe.sv
module phc_pipe
  import phc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  slot_t            fetch_slot,
  input  logic             fetch_take,
  input  logic             flush,
  input  logic             raw_stall,
  output slot_t [N_ST-1:0] stg
);

  slot_t q [N_ST];

  // fetch stage: loads a new slot or a bubble unless held by a dependency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  q[ST_FETCH] <= '0;
    else if (flush || !raw_stall) q[ST_FETCH] <= fetch_take ? fetch_slot : '0;
  end

  for (genvar s = 1; s < N_ST; s++) begin : g_stage
    localparam bit SQUASH_IN = (s - 1) <= ST_OPND;
    localparam bit HOLD      = s <= ST_ADDR;
    localparam bit BUBBLE    = s == ST_OPND;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q[s] <= '0;
      else if (flush && SQUASH_IN)     q[s] <= '0;
      else if (raw_stall && HOLD)      q[s] <= q[s];
      else if (raw_stall && BUBBLE)    q[s] <= '0;
      else                             q[s] <= q[s-1];
    end
  end

  for (genvar s = 0; s < N_ST; s++) begin : g_out
    assign stg[s] = q[s];
  end

endmodule

// File: rtl/phc_retire_ctr.sv
module phc_retire_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import phc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [TAG_W-1:0]      in_tag,
  input  logic [REG_W-1:0]      in_src_a,
  input  logic [REG_W-1:0]      in_src_b,
  input  logic [REG_W-1:0]      in_dst,
  input  logic                  in_wr_reg,
  input  logic                  in_mem,
  input  logic                  in_branch,
  input  logic                  in_taken,
  output logic                  fetch_ready,
  output logic                  flush,
  output logic                  raw_stall,
  output logic                  port_busy,
  output logic [N_ST-1:0]       stage_valid,
  output logic [N_ST*TAG_W-1:0] stage_tags,
  output logic                  retire_valid,
  output logic [TAG_W-1:0]      retire_tag,
  output logic [CNT_W-1:0]      done_count
);

  slot_t            fetch_slot;
  slot_t [N_ST-1:0] stg;
  logic             raw_hit;
  logic             fetch_take;

  always_comb begin
    fetch_slot.valid  = in_valid;
    fetch_slot.tag    = in_tag;
    fetch_slot.src_a  = in_src_a;
    fetch_slot.src_b  = in_src_b;
    fetch_slot.dst    = in_dst;
    fetch_slot.wr_reg = in_wr_reg;
    fetch_slot.mem    = in_mem;
    fetch_slot.branch = in_branch;
    fetch_slot.taken  = in_taken;
  end

  phc_hazard u_hz (
    .stg         (stg),
    .flush       (flush),
    .port_busy   (port_busy),
    .raw_hit     (raw_hit),
    .raw_stall   (raw_stall),
    .fetch_ready (fetch_ready)
  );

  assign fetch_take = in_valid & fetch_ready;

  phc_pipe u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_slot (fetch_slot),
    .fetch_take (fetch_take),
    .flush      (flush),
    .raw_stall  (raw_stall),
    .stg        (stg)
  );

  phc_retire_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (stg[ST_WRITE].valid),
    .count (done_count)
  );

  for (genvar s = 0; s < N_ST; s++) begin : g_view
    assign stage_valid[s]                 = stg[s].valid;
    assign stage_tags[s*TAG_W +: TAG_W]   = stg[s].tag;
  end

  assign retire_valid = stg[ST_WRITE].valid;
  assign retire_tag   = stg[ST_WRITE].tag;

endmodule

// File: rtl/phc_checker.sv
module phc_checker
  import phc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  raw_stall,
  input logic                  raw_hit,
  input logic                  port_busy,
  input logic                  fetch_ready,
  input logic [N_ST-1:0]       stage_valid,
  input logic [N_ST*TAG_W-1:0] stage_tags,
  input logic                  retire_valid,
  input logic [CNT_W-1:0]      done_count
);

  // R3: everything younger than the branch is gone after the flush edge
  assert_flush_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (stage_valid[ST_EXEC:ST_DEC] == '0));

  // R6: a busy port without other events leaves a bubble in fetch
  assert_port_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_busy && !raw_stall && !flush) |=> !stage_valid[ST_FETCH]);

  // R7: a dependency holds the address stage and empties the operand stage
  assert_raw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    raw_stall |=> (!stage_valid[ST_OPND] && stage_valid[ST_ADDR] &&
                   $stable(stage_tags[ST_ADDR*TAG_W +: TAG_W])));

  // R9: a detected dependency in a flush cycle never holds the pipeline
  assert_flush_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && raw_hit) |=> !stage_valid[ST_ADDR]);

  // R1: unobstructed movement from operand to execute carries the tag along
  assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_valid[ST_OPND] && !raw_stall && !flush) |=>
      (stage_valid[ST_EXEC] &&
       stage_tags[ST_EXEC*TAG_W +: TAG_W] == $past(stage_tags[ST_OPND*TAG_W +: TAG_W])));

  // R1: execute always hands over to write
  assert_exec_to_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stage_valid[ST_EXEC] |=> (retire_valid &&
      stage_tags[ST_WRITE*TAG_W +: TAG_W] == $past(stage_tags[ST_EXEC*TAG_W +: TAG_W])));

  // R10: the count follows retirements exactly
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> (done_count == $past(done_count) + CNT_W'(1)));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_valid |=> $stable(done_count));

  // R11: reset leaves an empty pipeline ready to fetch
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R11: assert (done_count == '0 && stage_valid == '0 && fetch_ready);
    end
  end

endmodule

bind pipe_hazard_ctrl phc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .raw_stall    (raw_stall),
  .raw_hit      (raw_hit),
  .port_busy    (port_busy),
  .fetch_ready  (fetch_ready),
  .stage_valid  (stage_valid),
  .stage_tags   (stage_tags),
  .retire_valid (retire_valid),
  .done_count   (done_count)
);

// File: tb/tb_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctrl;

  localparam int TW = 8;
  localparam int RW = 4;
  localparam int NS = 6;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic [RW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic in_wr_reg = 1'b0, in_mem = 1'b0, in_branch = 1'b0, in_taken = 1'b0;
  logic fetch_ready, flush, raw_stall, port_busy, retire_valid;
  logic [NS-1:0] stage_valid;
  logic [NS*TW-1:0] stage_tags;
  logic [TW-1:0] retire_tag;
  logic [CW-1:0] done_count;

  always #2.5 clk = ~clk;

  pipe_hazard_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .in_wr_reg(in_wr_reg), .in_mem(in_mem), .in_branch(in_branch), .in_taken(in_taken),
    .fetch_ready(fetch_ready), .flush(flush), .raw_stall(raw_stall), .port_busy(port_busy),
    .stage_valid(stage_valid), .stage_tags(stage_tags), .retire_valid(retire_valid),
    .retire_tag(retire_tag), .done_count(done_count)
  );

  int nchk = 0;
  int nfail = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // edge counter: number of rising edges since reset release
  int ecount = 0;
  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  // scoreboard of expected retirements
  typedef struct { int tag; int at; } exp_t;
  exp_t q[$];
  int nexp = 0;
  int last_ret = -1;

  task automatic expect_ret(input int tag, input int at);
    exp_t e;
    e.tag = tag;
    e.at  = at;
    q.push_back(e);
    nexp++;
  endtask

  always @(negedge clk) begin
    if (rst_n && retire_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected retire tag", int'(retire_tag), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(retire_tag) == e.tag, cur_req, "retire tag", int'(retire_tag), e.tag);
        chk(ecount == e.at, cur_req, "retire cycle", ecount, e.at);
        last_ret = ecount;
      end
    end
  end

  // program image for the driver
  int p_tag[16];
  int p_sa[16], p_sb[16], p_dst[16];
  bit p_wr[16], p_mem[16], p_br[16], p_tk[16];
  int plen = 0;
  int ptgt = 0;

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) begin
      p_tag[i] = 0; p_sa[i] = 14; p_sb[i] = 15; p_dst[i] = 0;
      p_wr[i] = 0; p_mem[i] = 0; p_br[i] = 0; p_tk[i] = 0;
    end
    plen = 0; ptgt = 0;
    q.delete();
    nexp = 0;
    last_ret = -1;
  endtask

  task automatic add(input int tag, input int sa, input int sb, input int dst,
                     input bit wr, input bit mem, input bit br, input bit tk);
    p_tag[plen] = tag; p_sa[plen] = sa; p_sb[plen] = sb; p_dst[plen] = dst;
    p_wr[plen] = wr; p_mem[plen] = mem; p_br[plen] = br; p_tk[plen] = tk;
    plen++;
  endtask

  task automatic plain(input int tag);
    add(tag, 14, 15, 0, 0, 0, 0, 0);
  endtask

  // statistics of the last run
  int nflush, flush_at, nraw, raw_first, nnr, nr_first;

  task automatic run(input int ncyc);
    int pc;
    bit prev;
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(stage_valid == '0, "R11", "stage_valid in reset", int'(stage_valid), 0);
    chk(done_count == '0, "R11", "done_count in reset", int'(done_count), 0);
    chk(fetch_ready && !flush && !raw_stall, "R11", "ready/flush/stall in reset",
        {29'd0, fetch_ready, flush, raw_stall}, 4);
    @(negedge clk);
    rst_n = 1'b1;
    pc = 0; prev = 1'b0;
    nflush = 0; flush_at = -1; nraw = 0; raw_first = -1; nnr = 0; nr_first = -1;
    for (int c = 0; c < ncyc; c++) begin
      if (c > 0) @(negedge clk);
      if (prev) pc++;
      if (flush) begin
        nflush++;
        if (flush_at < 0) flush_at = ecount;
        pc = ptgt;
      end
      if (raw_stall) begin
        nraw++;
        if (raw_first < 0) raw_first = ecount;
      end
      if (!fetch_ready) begin
        nnr++;
        if (nr_first < 0) nr_first = ecount;
      end
      if (pc < plen) begin
        in_valid  = 1'b1;
        in_tag    = TW'(p_tag[pc]);
        in_src_a  = RW'(p_sa[pc]);
        in_src_b  = RW'(p_sb[pc]);
        in_dst    = RW'(p_dst[pc]);
        in_wr_reg = p_wr[pc];
        in_mem    = p_mem[pc];
        in_branch = p_br[pc];
        in_taken  = p_tk[pc];
      end else begin
        in_valid = 1'b0;
      end
      prev = in_valid && fetch_ready;
    end
    chk(q.size() == 0, cur_req, "missing retirements", q.size(), 0);
    chk(int'(done_count) == nexp, "R10", "done_count after run", int'(done_count), nexp);
  endtask

  initial begin
    // R1/R2: nine independent instructions, one per cycle
    clear_prog();
    cur_req = "R2";
    for (int i = 1; i <= 9; i++) begin
      plain(i);
      expect_ret(i, i + 5);
    end
    run(22);
    chk(last_ret == 14, "R2", "cycle of last retirement", last_ret, 14);
    chk(nraw == 0 && nflush == 0 && nnr == 0, "R1", "no hazard signals", nraw + nflush + nnr, 0);

    // R3/R4: third instruction is a taken branch to the tag-15 path
    clear_prog();
    cur_req = "R3";
    plain(1); plain(2); add(3, 14, 15, 0, 0, 0, 1, 1);
    plain(4); plain(5); plain(6); plain(7);
    plain(15); plain(16);
    ptgt = 7;
    expect_ret(1, 6); expect_ret(2, 7); expect_ret(3, 8);
    expect_ret(15, 13); expect_ret(16, 14);
    run(22);
    chk(nflush == 1, "R3", "flush cycles", nflush, 1);
    chk(flush_at == 7, "R3", "flush cycle", flush_at, 7);
    chk(last_ret == 14, "R4", "target path retire end", last_ret, 14);

    // R5: branch not taken
    clear_prog();
    cur_req = "R5";
    add(1, 14, 15, 0, 0, 0, 1, 0); plain(2); plain(3);
    expect_ret(1, 6); expect_ret(2, 7); expect_ret(3, 8);
    run(16);
    chk(nflush == 0, "R5", "flush cycles", nflush, 0);

    // R7: back-to-back dependency on r1 costs three cycles
    clear_prog();
    cur_req = "R7";
    add(1, 14, 15, 1, 1, 0, 0, 0); add(2, 1, 15, 0, 0, 0, 0, 0); plain(3); plain(4);
    expect_ret(1, 6); expect_ret(2, 10); expect_ret(3, 11); expect_ret(4, 12);
    run(20);
    chk(nraw == 3, "R7", "stall cycles distance 1", nraw, 3);
    chk(raw_first == 4, "R7", "first stall cycle", raw_first, 4);

    // R7: dependency two instructions apart costs two cycles
    clear_prog();
    cur_req = "R7";
    add(1, 14, 15, 6, 1, 0, 0, 0); plain(2); add(3, 6, 15, 0, 0, 0, 0, 0);
    expect_ret(1, 6); expect_ret(2, 7); expect_ret(3, 10);
    run(18);
    chk(nraw == 2, "R7", "stall cycles distance 2", nraw, 2);
    chk(raw_first == 5, "R7", "first stall cycle", raw_first, 5);

    // R8: non-writing producer ignored, writing one on src_b stalls
    clear_prog();
    cur_req = "R8";
    add(1, 14, 15, 2, 0, 0, 0, 0); add(2, 2, 15, 3, 1, 0, 0, 0); add(3, 14, 3, 0, 0, 0, 0, 0);
    expect_ret(1, 6); expect_ret(2, 7); expect_ret(3, 11);
    run(18);
    chk(nraw == 3, "R8", "stall cycles", nraw, 3);
    chk(raw_first == 5, "R8", "no stall before cycle 5", raw_first, 5);

    // R6: one memory operand idles fetch for one cycle
    clear_prog();
    cur_req = "R6";
    add(1, 14, 15, 0, 0, 1, 0, 0); plain(2); plain(3); plain(4); plain(5);
    expect_ret(1, 6); expect_ret(2, 7); expect_ret(3, 8); expect_ret(4, 9); expect_ret(5, 11);
    run(18);
    chk(nnr == 1, "R6", "fetch idle cycles", nnr, 1);
    chk(nr_first == 4, "R6", "fetch idle cycle", nr_first, 4);

    // R6: two consecutive memory operands idle fetch for two cycles
    clear_prog();
    cur_req = "R6";
    add(1, 14, 15, 0, 0, 1, 0, 0); add(2, 14, 15, 0, 0, 1, 0, 0); plain(3); plain(4); plain(5);
    expect_ret(1, 6); expect_ret(2, 7); expect_ret(3, 8); expect_ret(4, 9); expect_ret(5, 12);
    run(18);
    chk(nnr == 2, "R6", "fetch idle cycles", nnr, 2);

    // R9: flush in the same cycle as a dependency and a busy port
    clear_prog();
    cur_req = "R9";
    add(1, 14, 15, 0, 0, 0, 1, 1); add(2, 14, 15, 5, 1, 1, 0, 0); add(3, 5, 15, 0, 0, 0, 0, 0);
    plain(4); plain(5); plain(20); plain(21);
    ptgt = 5;
    expect_ret(1, 6); expect_ret(20, 11); expect_ret(21, 12);
    run(18);
    chk(nraw == 0, "R9", "stall cycles under flush", nraw, 0);
    chk(nnr == 0, "R9", "fetch idle cycles under flush", nnr, 0);
    chk(flush_at == 5, "R9", "flush cycle", flush_at, 5);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule